// File: doc/BRIEF.md
# Register Half Packing Unit

This block builds one result from two source operands. It takes selected fields of each operand and places them side by side in the result. There are three packing modes. The full-half mode joins the low half of each operand. The byte mode joins the low byte of each operand and fills every higher bit with zero. On a 64-bit datapath, the word mode joins the low 16 bits of each operand and sign-extends the 32-bit value to the full width.

A caller presents both operand values, the register index of the second operand, a mode code and a valid strobe. The unit answers one cycle later with a registered result and a valid flag. Register index zero always reads as a zero operand. On a 32-bit datapath, the full-half mode with that index is the zero-extend-halfword operation. The unit raises a separate flag for that case. The result is the same as the full-half mode with a zero second operand.

Top module: `packUnit`

## Requirements
- R1: Mode code 2'b00 (full-half): result bits [XLEN/2-1:0] equal opA[XLEN/2-1:0] and bits [XLEN-1:XLEN/2] equal the low half of the second operand.
- R2: Mode code 2'b01 (byte): result bits [7:0] equal opA[7:0], bits [15:8] equal the second operand's bits [7:0], and all higher bits are zero.
- R3: Mode code 2'b10 (word, XLEN=64 only): result bits [15:0] equal opA[15:0], bits [31:16] equal the second operand's bits [15:0], and bits [63:32] all copy bit 31.
- R4: Mode code 2'b11 is reserved. Mode 2'b10 is also reserved when XLEN is below 64. A reserved request gives outValid low on the next cycle and leaves result unchanged.
- R5: When opBIdx is 0, the second operand is taken as zero in every mode, whatever value is on opB.
- R6: isZext is high, one cycle after an accepted request, only when XLEN=32, the mode is 2'b00 and opBIdx is 0. The result is then opA zero-extended from 16 bits. In every other case isZext is low.
- R7: An accepted request (inValid high, mode not reserved) gives outValid high on the next cycle, with the result on that cycle. Without an accepted request, outValid is low and result holds its last value.
- R8: While rstN is low, outValid, isZext and result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| mode | input | 2 | Packing mode code |
| opA | input | XLEN | First operand value |
| opB | input | XLEN | Second operand value |
| opBIdx | input | 5 | Register index of the second operand |
| outValid | output | 1 | Result valid, one cycle after the request |
| isZext | output | 1 | Zero-extend-halfword case flag |
| result | output | XLEN | Packed result |

## Verification
The hardest case to reach is the zero-extend-halfword alias with a nonzero value on the operand bus. Only that combination shows that the index, not the data, zeroes the upper half. Random stimulus rarely draws index zero, so the bench forces it on about a quarter of requests. It also adds directed cases that put all-ones data on the second operand. The 32-bit and 64-bit versions run side by side on the same stimulus. This shows that the word mode is rejected in the narrow version and sign-extends in the wide one, including when bit 31 is set.

// File: rtl/packUnitPkg.sv
package packUnitPkg;
  typedef enum logic [1:0] {
    MODE_HALF = 2'b00,
    MODE_BYTE = 2'b01,
    MODE_WORD = 2'b10,
    MODE_RSVD = 2'b11
  } packMode_e;

  typedef struct packed {
    logic fire;
    logic selHalf;
    logic selByte;
    logic selWord;
    logic zeroB;
  } packCtrl_t;
endpackage

// File: rtl/packCtrl.sv
module packCtrl
  import packUnitPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [1:0] mode,
  input  logic [4:0] opBIdx,
  output packCtrl_t ctrl,
  output logic      outValid,
  output logic      isZext
);
  localparam bit HasWord = (XLEN >= 64);
  localparam bit HasZext = (XLEN == 32);

  logic legal;
  logic zextDec;

  always_comb begin
    legal = 1'b0;
    case (packMode_e'(mode))
      MODE_HALF: legal = 1'b1;
      MODE_BYTE: legal = 1'b1;
      MODE_WORD: legal = HasWord;
      default:   legal = 1'b0;
    endcase
    ctrl.fire    = inValid && legal;
    ctrl.selHalf = (packMode_e'(mode) == MODE_HALF);
    ctrl.selByte = (packMode_e'(mode) == MODE_BYTE);
    ctrl.selWord = (packMode_e'(mode) == MODE_WORD) && HasWord;
    ctrl.zeroB   = (opBIdx == 5'd0);
    zextDec      = HasZext && ctrl.selHalf && ctrl.zeroB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      isZext   <= 1'b0;
    end else begin
      outValid <= ctrl.fire;
      isZext   <= ctrl.fire && zextDec;
    end
  end
endmodule

// File: rtl/packDatapath.sv
module packDatapath
  import packUnitPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  packCtrl_t       ctrl,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);
  localparam int Half = XLEN / 2;

  logic [XLEN-1:0] opBEff;
  logic [XLEN-1:0] halfRes;
  logic [XLEN-1:0] byteRes;
  logic [XLEN-1:0] wordRes;
  logic [XLEN-1:0] nextRes;
  logic [31:0]     wordLow;

  assign opBEff  = ctrl.zeroB ? '0 : opB;
  assign halfRes = {opBEff[Half-1:0], opA[Half-1:0]};
  assign wordLow = {opBEff[15:0], opA[15:0]};

  always_comb begin
    byteRes       = '0;
    byteRes[15:0] = {opBEff[7:0], opA[7:0]};
  end

  generate
    if (XLEN >= 64) begin : gWide
      assign wordRes = {{(XLEN-32){wordLow[31]}}, wordLow};
    end else begin : gNarrow
      assign wordRes = '0;
    end
  endgenerate

  always_comb begin
    nextRes = halfRes;
    if (ctrl.selByte)      nextRes = byteRes;
    else if (ctrl.selWord) nextRes = wordRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          result <= '0;
    else if (ctrl.fire) result <= nextRes;
  end
endmodule

// File: rtl/packUnit.sv
module packUnit
  import packUnitPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [4:0]      opBIdx,
  output logic            outValid,
  output logic            isZext,
  output logic [XLEN-1:0] result
);
  packCtrl_t ctrl;

  packCtrl #(.XLEN(XLEN)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .opBIdx(opBIdx), .ctrl(ctrl), .outValid(outValid), .isZext(isZext)
  );

  packDatapath #(.XLEN(XLEN)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .result(result)
  );
endmodule

// File: rtl/packUnitChk.sv
module packUnitChk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [1:0]      mode,
  input logic            outValid,
  input logic            isZext,
  input logic [XLEN-1:0] result
);
  // R7
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result));

  // R6
  zext_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    isZext |-> outValid);

  // R4
  reserved_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(mode) == 2'b11) |-> !outValid);

  // R2
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(mode) == 2'b01) |-> (result[XLEN-1:16] == '0));

  generate
    if (XLEN >= 64) begin : gWordChk
      // R3
      word_sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && $past(mode) == 2'b10) |->
          (result[XLEN-1:32] == {(XLEN-32){result[31]}}));
    end else begin : gNoWordChk
      // R4
      narrow_word_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(inValid) && $past(mode) == 2'b10) |-> !outValid);
    end
  endgenerate
endmodule

bind packUnit packUnitChk #(.XLEN(XLEN)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
  .outValid(outValid), .isZext(isZext), .result(result)
);

// File: tb/tb_packUnit.sv
module tb_packUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [4:0] opBIdx = 5'd1;
  logic outValid, isZext, outValid32, isZext32;
  logic [63:0] result;
  logic [31:0] result32;
  int checks = 0;
  int fails = 0;
  logic [63:0] last64 = '0;
  logic [31:0] last32 = '0;

  always #4 clk = ~clk;

  packUnit #(.XLEN(64)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .opA(opA),
    .opB(opB), .opBIdx(opBIdx), .outValid(outValid), .isZext(isZext),
    .result(result)
  );

  packUnit #(.XLEN(32)) dut32 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .opA(opA[31:0]),
    .opB(opB[31:0]), .opBIdx(opBIdx), .outValid(outValid32), .isZext(isZext32),
    .result(result32)
  );

  function automatic logic [63:0] ref64(logic [1:0] m, logic [63:0] a,
                                        logic [63:0] b, logic [4:0] idx);
    logic [63:0] bb = (idx == 0) ? 64'd0 : b;
    case (m)
      2'b00: return {bb[31:0], a[31:0]};
      2'b01: return {48'd0, bb[7:0], a[7:0]};
      default: return {{32{bb[15]}}, bb[15:0], a[15:0]};
    endcase
  endfunction

  function automatic logic [31:0] ref32(logic [1:0] m, logic [31:0] a,
                                        logic [31:0] b, logic [4:0] idx);
    logic [31:0] bb = (idx == 0) ? 32'd0 : b;
    if (m == 2'b00) return {bb[15:0], a[15:0]};
    return {16'd0, bb[7:0], a[7:0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [1:0] m, logic [63:0] a, logic [63:0] b,
                       logic [4:0] idx);
    logic ok64, ok32;
    @(negedge clk);
    inValid = v; mode = m; opA = a; opB = b; opBIdx = idx;
    @(negedge clk);
    inValid = 1'b0;
    ok64 = v && (m != 2'b11);
    ok32 = v && (m == 2'b00 || m == 2'b01);
    if (ok64) last64 = ref64(m, a, b, idx);
    if (ok32) last32 = ref32(m, a[31:0], b[31:0], idx);
    // R7 R4 valid and hold, R1 R2 R3 R5 values
    check(m == 2'b11 ? "R4 valid64" : "R7 valid64", {63'd0, outValid}, {63'd0, ok64});
    check(m == 2'b00 ? "R1 R5 result64" : (m == 2'b01 ? "R2 R5 result64" :
          (m == 2'b10 ? "R3 result64" : "R4 hold64")), result, last64);
    check(m[1] ? "R4 valid32" : "R7 valid32", {63'd0, outValid32}, {63'd0, ok32});
    check("R1 R2 R4 result32", {32'd0, result32}, {32'd0, last32});
    // R6
    check("R6 zext64", {63'd0, isZext}, 64'd0);
    check("R6 zext32", {63'd0, isZext32},
          {63'd0, ok32 && m == 2'b00 && idx == 0});
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset valid", {62'd0, outValid, outValid32}, 64'd0);
    check("R8 reset zext", {62'd0, isZext, isZext32}, 64'd0);
    check("R8 reset result", result | {32'd0, result32}, 64'd0);
    rstN = 1'b1;
    // directed corners
    apply(1, 2'b00, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 5'd3);
    apply(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0); // R5 R6
    apply(1, 2'b01, 64'hFFFF_FFFF_FFFF_FF12, 64'hFFFF_FFFF_FFFF_FF34, 5'd9);
    apply(1, 2'b10, 64'h0000_0000_0000_5678, 64'h0000_0000_0000_8234, 5'd4); // R3 negative
    apply(1, 2'b10, 64'hFFFF_FFFF_FFFF_5678, 64'hFFFF_FFFF_FFFF_7234, 5'd4); // R3 positive
    apply(1, 2'b10, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0);               // R5 word
    apply(1, 2'b11, 64'hDEAD_BEEF, 64'hCAFE, 5'd2);                          // R4
    apply(0, 2'b01, 64'h55, 64'h66, 5'd2);                                   // R7 idle
    for (int i = 0; i < 400; i++) begin
      logic [4:0] idx = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      apply(($urandom % 8) != 0, 2'($urandom), {$urandom, $urandom},
            {$urandom, $urandom}, idx);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule